// File: doc/BRIEF.md
# Value-Bit Masked Command Register

This block is a 32-bit control register for a network controller. A write does not replace the stored word. Each of the four bytes is updated through a set/clear scheme instead. In every byte, the top bit of the written data is the value to apply. The seven bits below it form a selection map. A stored bit whose map bit is 1 takes the value bit. A stored bit whose map bit is 0 keeps its old contents. Software can therefore turn single control bits on or off without reading the register first.

The register sits on a simple register bus: a write strobe, an address match, write data and read data. The stored control bits also leave the block as individually named outputs. These feed the receive filter, the media-access logic and the interrupt logic.

The register has two ways to clear:
- A synchronous hard reset clears every bit.
- A soft-stop input, used when the controller stops running, clears every stored bit except the broadcast-receive disable.

Reserved positions and value-bit positions are never stored, and they always read 0.

Top module: `cmdmask_reg`

## Requirements
- R1: A cycle with `rst` high leaves `rdata` and every named output at 0 after that clock edge. This includes bit 17, whatever its earlier value.
- R2: A write is a clock edge with both `wr_en` and `addr_hit` high. For each byte b (bits 8b+7..8b), when write bit 8b+7 is 1, every stored bit 8b+i (i = 0..6) whose write bit 8b+i is 1 becomes 1.
- R3: In the same write, when write bit 8b+7 is 0, every stored bit 8b+i whose write bit 8b+i is 1 becomes 0.
- R4: Stored bits whose map bit is 0 keep their value. A byte whose seven map bits are all 0 is left unchanged, whatever its value bit, and the other bytes are still updated.
- R5: Bits 31, 30, 28:24, 23, 22:20, 15, 14, 8 and 7 always read 0, whatever is written. The implemented bits are 29, 19:16, 13:9 and 6:0.
- R6: A clock edge where `wr_en` or `addr_hit` is low, and `soft_stop` and `rst` are low, leaves the register unchanged.
- R7: A clock edge with `soft_stop` high (and `rst` low) clears all stored bits except bit 17, which keeps its value. If a write occurs at the same edge, bit 17 takes the written result.
- R8: The named outputs equal these stored bits:

  | Output | Bit |
  |---|---|
  | `conduit_mode` | 29 |
  | `runt_accept` | 19 |
  | `no_phys_rx` | 18 |
  | `no_bcast_rx` | 17 |
  | `promisc` | 16 |
  | `rx_pad_strip` | 13 |
  | `ring0_drop` | 12 |
  | `alt_backoff` | 11 |
  | `no_defer2` | 10 |
  | `last_tx_irq_en` | 9 |
  | `aux_ctl` | 6:0 |

- R9: The result of a write or clear appears on `rdata` after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_stop | input | 1 | Controller-stop clear; keeps broadcast disable |
| wr_en | input | 1 | Bus write strobe |
| addr_hit | input | 1 | Bus address matches this register |
| wdata | input | 32 | Write data: per byte, value bit on top, 7-bit map below |
| rdata | output | 32 | Stored register contents |
| conduit_mode | output | 1 | Backoff and retry disabled |
| runt_accept | output | 1 | Accept short receive frames |
| no_phys_rx | output | 1 | Disable own-address receive match |
| no_bcast_rx | output | 1 | Disable broadcast receive |
| promisc | output | 1 | Accept all receive frames |
| rx_pad_strip | output | 1 | Automatic receive pad strip |
| ring0_drop | output | 1 | Drop ring-0 frames when no descriptor is free |
| alt_backoff | output | 1 | Modified backoff enable |
| no_defer2 | output | 1 | Disable two-part transmit deferral |
| last_tx_irq_en | output | 1 | Last-transmit interrupt enable |
| aux_ctl | output | 7 | General control bits of byte 0 |

## Verification
Every result of this block is due exactly one clock edge after its stimulus is sampled: a masked write, a soft stop and a reset. The bench changes inputs on the falling edge, waits for one rising edge, and compares `rdata` and the named outputs on the next falling edge against a bench model updated in step. One directed check samples `rdata` before the rising edge, to show the old value still holds there. No result is ever checked in the same half-cycle as the stimulus.

// File: rtl/cmdmask_pkg.sv
package cmdmask_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 8;

  // Implemented storage: 29, 19:16, 13:9, 6:0
  localparam logic [31:0] IMPL_DEF = 32'h200F_3E7F;
  // Bits that survive a soft stop: broadcast receive disable
  localparam logic [31:0] KEEP_DEF = 32'h0002_0000;

  localparam int unsigned B_CONDUIT  = 29;
  localparam int unsigned B_RUNT     = 19;
  localparam int unsigned B_NOPHYS   = 18;
  localparam int unsigned B_NOBCAST  = 17;
  localparam int unsigned B_PROMISC  = 16;
  localparam int unsigned B_PADSTRIP = 13;
  localparam int unsigned B_R0DROP   = 12;
  localparam int unsigned B_ALTBOFF  = 11;
  localparam int unsigned B_NODEFER2 = 10;
  localparam int unsigned B_LTIRQ    = 9;
  localparam int unsigned AUX_W      = 7;
endpackage

// File: rtl/cmdmask_lane.sv
// One byte lane: top bit of the write byte is the value, lower bits are the map.
module cmdmask_lane #(
  parameter int unsigned LANE_W = 8,
  parameter logic [LANE_W-1:0] IMPL = '1
) (
  input  logic              we,
  input  logic [LANE_W-1:0] old_q,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] nxt
);
  localparam int unsigned MAP_W = LANE_W - 1;

  logic             val;
  logic [MAP_W-1:0] map;
  logic [MAP_W-1:0] merged;

  assign val = wbyte[LANE_W-1];
  assign map = wbyte[MAP_W-1:0];

  always_comb begin
    if (we) begin
      merged = (old_q[MAP_W-1:0] & ~map) | (map & {MAP_W{val}});
    end else begin
      merged = old_q[MAP_W-1:0];
    end
  end

  // value-bit position is never stored; reserved bits are forced to zero
  assign nxt = {1'b0, merged} & IMPL;
endmodule

// File: rtl/cmdmask_hold.sv
// Storage flops with hard reset and soft-stop clear.
module cmdmask_hold #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEEP_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_stop,
  input  logic [DATA_W-1:0] nxt,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (soft_stop) begin
      q <= nxt & KEEP_MASK;
    end else begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/cmdmask_reg.sv
module cmdmask_reg
  import cmdmask_pkg::*;
#(
  parameter int unsigned NUM_LANES = LANES_DEF,
  parameter int unsigned LANE_W    = LANE_W_DEF,
  parameter logic [NUM_LANES*LANE_W-1:0] IMPL_MASK = IMPL_DEF,
  parameter logic [NUM_LANES*LANE_W-1:0] KEEP_MASK = KEEP_DEF
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        soft_stop,
  input  logic                        wr_en,
  input  logic                        addr_hit,
  input  logic [NUM_LANES*LANE_W-1:0] wdata,
  output logic [NUM_LANES*LANE_W-1:0] rdata,
  output logic                        conduit_mode,
  output logic                        runt_accept,
  output logic                        no_phys_rx,
  output logic                        no_bcast_rx,
  output logic                        promisc,
  output logic                        rx_pad_strip,
  output logic                        ring0_drop,
  output logic                        alt_backoff,
  output logic                        no_defer2,
  output logic                        last_tx_irq_en,
  output logic [AUX_W-1:0]            aux_ctl
);
  localparam int unsigned DATA_W = NUM_LANES * LANE_W;

  logic              we;
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] nxt;

  assign we = wr_en & addr_hit;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    cmdmask_lane #(
      .LANE_W (LANE_W),
      .IMPL   (IMPL_MASK[g*LANE_W +: LANE_W])
    ) u_lane (
      .we    (we),
      .old_q (q[g*LANE_W +: LANE_W]),
      .wbyte (wdata[g*LANE_W +: LANE_W]),
      .nxt   (nxt[g*LANE_W +: LANE_W])
    );
  end

  cmdmask_hold #(
    .DATA_W    (DATA_W),
    .KEEP_MASK (KEEP_MASK)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .soft_stop (soft_stop),
    .nxt       (nxt),
    .q         (q)
  );

  assign rdata          = q;
  assign conduit_mode   = q[B_CONDUIT];
  assign runt_accept    = q[B_RUNT];
  assign no_phys_rx     = q[B_NOPHYS];
  assign no_bcast_rx    = q[B_NOBCAST];
  assign promisc        = q[B_PROMISC];
  assign rx_pad_strip   = q[B_PADSTRIP];
  assign ring0_drop     = q[B_R0DROP];
  assign alt_backoff    = q[B_ALTBOFF];
  assign no_defer2      = q[B_NODEFER2];
  assign last_tx_irq_en = q[B_LTIRQ];
  assign aux_ctl        = q[AUX_W-1:0];
endmodule

// File: rtl/cmdmask_reg_chk.sv
module cmdmask_reg_chk #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1,
  parameter logic [DATA_W-1:0] KEEP_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_stop,
  input logic              wr_en,
  input logic              addr_hit,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == '0);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) == 1'b0 |-> (rdata & ~IMPL_MASK) == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(soft_stop) && !$past(wr_en && addr_hit))
      |-> $stable(rdata));

  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(soft_stop)) |-> (rdata & ~KEEP_MASK) == '0);

  // R7
  soft_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(soft_stop) && !$past(wr_en && addr_hit))
      |-> (rdata & KEEP_MASK) == ($past(rdata) & KEEP_MASK));

  // R4
  empty_map_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(soft_stop) && $past(wr_en && addr_hit)
      && $past(wdata[30:24]) == 7'd0)
      |-> rdata[31:24] == $past(rdata[31:24]));
endmodule

bind cmdmask_reg cmdmask_reg_chk #(
  .DATA_W    (DATA_W),
  .IMPL_MASK (IMPL_MASK),
  .KEEP_MASK (KEEP_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .soft_stop (soft_stop),
  .wr_en     (wr_en),
  .addr_hit  (addr_hit),
  .wdata     (wdata),
  .rdata     (rdata)
);

// File: tb/test_cmdmask_reg.sv
`timescale 1ns/1ps
module test_cmdmask_reg;
  localparam logic [31:0] IMPL = 32'h200F_3E7F;
  localparam logic [31:0] KEEP = 32'h0002_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_stop = 1'b0;
  logic wr_en = 1'b0;
  logic addr_hit = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic conduit_mode, runt_accept, no_phys_rx, no_bcast_rx, promisc;
  logic rx_pad_strip, ring0_drop, alt_backoff, no_defer2, last_tx_irq_en;
  logic [6:0] aux_ctl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_q = '0;

  always #5 clk = ~clk;

  cmdmask_reg i_cmdmask_reg (
    .clk(clk), .rst(rst), .soft_stop(soft_stop), .wr_en(wr_en),
    .addr_hit(addr_hit), .wdata(wdata), .rdata(rdata),
    .conduit_mode(conduit_mode), .runt_accept(runt_accept),
    .no_phys_rx(no_phys_rx), .no_bcast_rx(no_bcast_rx), .promisc(promisc),
    .rx_pad_strip(rx_pad_strip), .ring0_drop(ring0_drop),
    .alt_backoff(alt_backoff), .no_defer2(no_defer2),
    .last_tx_irq_en(last_tx_irq_en), .aux_ctl(aux_ctl)
  );

  function automatic logic [31:0] model_write(logic [31:0] old, logic [31:0] d);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 7; i++) begin
        if (d[8*b+i]) r[8*b+i] = d[8*b+7];
      end
    end
    return r & IMPL;
  endfunction

  function automatic logic [31:0] outs_vec();
    logic [31:0] v;
    v = '0;
    v[29] = conduit_mode;   v[19] = runt_accept; v[18] = no_phys_rx;
    v[17] = no_bcast_rx;    v[16] = promisc;     v[13] = rx_pad_strip;
    v[12] = ring0_drop;     v[11] = alt_backoff; v[10] = no_defer2;
    v[9]  = last_tx_irq_en; v[6:0] = aux_ctl;
    return v;
  endfunction

  task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check_val(req, rdata, exp_q);
    check_val("R8", outs_vec(), exp_q);
  endtask

  // Apply one cycle of stimulus at the falling edge; result checked one edge later.
  task automatic step(bit en, bit hit, bit ss, logic [31:0] d);
    logic [31:0] nxt;
    wr_en = en; addr_hit = hit; soft_stop = ss; wdata = d;
    nxt = (en && hit) ? model_write(exp_q, d) : exp_q;
    if (ss) nxt = nxt & KEEP;
    @(posedge clk);
    exp_q = nxt;
    @(negedge clk);
    wr_en = 1'b0; addr_hit = 1'b0; soft_stop = 1'b0; wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    exp_q = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    check_all("R1");

    // R2: set all implemented bits in every byte
    step(1, 1, 0, 32'hFFFF_FFFF);
    check_all("R2");
    check_val("R5", rdata & ~IMPL, 32'h0);

    // R3: clear byte 2 map bits only
    step(1, 1, 0, 32'h0002_7F00 & 32'h00FF_0000 | 32'h007F_0000);
    check_all("R3");
    check_val("R3", rdata & 32'h00FF_0000, 32'h0);

    // R4: empty maps with value bits set -> nothing changes
    step(1, 1, 0, 32'h8080_8080);
    check_all("R4");

    // R4: byte 1 map zero, byte 0 cleared partially
    step(1, 1, 0, 32'h0000_8005);
    check_all("R4");

    // R6: strobe without address match, then match without strobe
    step(1, 0, 0, 32'h7F7F_7F7F);
    check_all("R6");
    step(0, 1, 0, 32'h7F7F_7F7F);
    check_all("R6");

    // R9: value unchanged before the edge, new after
    wr_en = 1'b1; addr_hit = 1'b1; wdata = 32'h0000_7F7F;
    #4;
    check_val("R9", rdata, exp_q);
    wr_en = 1'b0; addr_hit = 1'b0; wdata = '0;
    step(1, 1, 0, 32'h0000_7F7F);
    check_all("R9");

    // R7: set bit 17 and others, then soft stop keeps only bit 17
    step(1, 1, 0, 32'hA0AE_BE7F);
    check_all("R2");
    step(0, 0, 1, 32'h0);
    check_all("R7");
    check_val("R7", rdata, 32'h0002_0000);

    // R7: soft stop with write clearing bit 17 at the same edge
    step(1, 1, 1, 32'h0002_0000 | 32'h0000_0000);
    check_all("R7");
    step(1, 1, 1, 32'h8082_FF7F);
    check_all("R7");
    check_val("R7", rdata, 32'h0002_0000);

    // R1: hard reset clears bit 17
    do_reset();
    check_all("R1");

    // Random mix: R2 R3 R4 R5 R6 R7
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      bit en, hit, ss;
      d   = $urandom();
      en  = ($urandom_range(0, 9) != 0);
      hit = ($urandom_range(0, 9) != 0);
      ss  = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 4) == 0) d[30:24] = 7'd0;
      step(en, hit, ss, d);
      check_all("R2_R3_R4_R6_R7");
      check_val("R5", rdata & ~IMPL, 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule